// File: doc/BRIEF.md
# Source-Clock Divider and Low-Power Mode Controller

This block produces the system clock-enable strobe for a microcontroller core from one of two oscillator sources, a crystal and an internal RC oscillator. Both oscillators sit outside the block. Each is seen only as a one-cycle tick input and, for the crystal, a ready level. The block runs on a fast sampling clock. Each source tick moves a divider on by one step, and `clk_en` pulses once for every N ticks. Software selects N through a small configuration write port: 1, 2, 4 or 8 in normal operation, or 256 while the power-saving bit is set. The power-saving bit can be cleared by hardware: when switchback is enabled, any enabled interrupt request clears it and the divider restarts at the normal ratio.

A stop request halts both oscillators and the strobe. The block leaves stop only when an enabled interrupt from a line marked as external arrives, or when reset is applied. A policy bit selects how the block wakes. With the bit clear, it waits for the crystal to report ready before any strobe is produced. With the bit set, it runs at once from the RC oscillator and moves to the crystal on an RC tick boundary once the synchronized ready signal is high. After reset the block runs from the RC oscillator with the crystal starting, which is the same warm-up path as the second wake policy.

Top module: `clkpm_ctrl`

## Requirements
- R1: After reset: `sel_rc`=1, `rc_run`=1, `xtal_run`=1, `stop_q`=0, `pmm_q`=0, `ratio_q`=0, `clk_en`=0, and the divider divides by 1.
- R2: With ratio code k (0..3) in `ratio_q` and the power-saving bit clear, `clk_en` is high for one cycle on every 2^k-th counted source tick. It rises in the cycle after the edge that samples that tick.
- R3: A new ratio or power-saving setting is loaded only at the terminal tick of the current division period. The period in progress completes at its old length.
- R4: While `pmm_q`=1, the divider divides by 256 whatever the ratio code holds.
- R5: If `pmm_q`=1 and switchback is enabled, any request with `irq_req[i] & irq_en[i]` clears `pmm_q` at the next edge and restarts the count at the normal ratio. If switchback is disabled, or no enabled request is present, `pmm_q` stays set.
- R6: A configuration write with `cfg_stop`=1 sets `stop_q`=1 and clears `xtal_run` and `rc_run` at the next edge. While `stop_q`=1, no tick produces `clk_en`.
- R7: Stop is left only in two ways: when `irq_req & irq_en & EXT_MASK` is non-zero (default mask 4'b0011: lines 0 and 1 are external), or by reset. An enabled request on a non-external line, or a disabled external request, leaves `stop_q`=1.
- R8: If wake policy `cfg_wake_rc`=0, the block leaves stop with `xtal_run`=1, `rc_run`=0, `sel_rc`=0 and counts no tick until the synchronized crystal ready is high.
- R9: If wake policy `cfg_wake_rc`=1, the block leaves stop with `sel_rc`=1, `rc_run`=1, `xtal_run`=1 and counts only RC ticks. It switches to the crystal (`sel_rc`=0, `rc_run`=0) on the first RC tick seen while the synchronized ready signal is high. That tick is still counted.
- R10: `xtal_rdy_raw` passes through a two-stage synchronizer. A rise sampled at edge e allows crystal ticks to be counted from edge e+3 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xtal_tick | input | 1 | One-cycle pulse per crystal period |
| rc_tick | input | 1 | One-cycle pulse per RC oscillator period |
| xtal_rdy_raw | input | 1 | Crystal stable indication, asynchronous |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ratio | input | RATIO_W | Normal divide code k, divide by 2^k |
| cfg_pmm | input | 1 | Power-saving divide-by-256 enable |
| cfg_swb | input | 1 | Switchback enable |
| cfg_wake_rc | input | 1 | Stop wake policy: 1 = run from RC at once |
| cfg_stop | input | 1 | Enter stop (acts with cfg_we) |
| irq_req | input | N_IRQ | Interrupt requests |
| irq_en | input | N_IRQ | Interrupt enables |
| clk_en | output | 1 | System clock-enable strobe |
| xtal_run | output | 1 | Crystal oscillator run control |
| rc_run | output | 1 | RC oscillator run control |
| sel_rc | output | 1 | 1 = RC ticks drive the divider |
| stop_q | output | 1 | Stop mode active |
| pmm_q | output | 1 | Power-saving bit readback |
| ratio_q | output | RATIO_W | Ratio code readback |

## Verification
The strobe is due one cycle after the edge that samples the terminal tick. Register readback and stop or wake changes are due one cycle after the edge that samples the write or the request. A crystal ready rise takes three edges to affect counting. The driver queues each tick together with its expected strobe level, tagged with the cycle number one beyond the sampling edge. The monitor pops each item at the falling edge of that exact cycle, so every check samples away from the active edge and at the latency stated above. Mode and oscillator outputs are checked directly at the falling edge after the edge that acts on the stimulus.

// File: rtl/clkpm_pkg.sv
// Shared types for the clock divider and low-power mode controller.
package clkpm_pkg;

    // Oscillator / power state of the controller.
    typedef enum logic [1:0] {
        OSC_RC   = 2'd0,   // running from RC oscillator, crystal warming
        OSC_XTAL = 2'd1,   // running from crystal, RC off
        OSC_STOP = 2'd2,   // everything halted
        OSC_WAIT = 2'd3    // crystal started, strobe held until ready
    } osc_state_e;

endpackage

// File: rtl/clkpm_sync.sv
// Multi-stage level synchronizer for an asynchronous status input.
// Assumes the input is a slow level; output lags by STAGES edges.
module clkpm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift the level one stage further per edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else if (g == 0) begin
                    chain[g] <= d_async;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/clkpm_modereg.sv
// Mode register: holds the ratio code, the power-saving bit, the switchback
// enable and the wake policy. Hardware switchback clears the power-saving
// bit and asks the divider to restart. Assumes writes are single-cycle.
module clkpm_modereg #(
    parameter int RATIO_W = 2,
    parameter int N_IRQ   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               cfg_pmm,
    input  logic               cfg_swb,
    input  logic               cfg_wake_rc,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic [N_IRQ-1:0]   irq_en,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               pmm_q,
    output logic               wake_rc_q,
    output logic               swb_hit
);
    logic swb_q;
    logic any_irq;

    // Detect an enabled request while switchback may fire.
    always_comb begin
        any_irq = |(irq_req & irq_en);
        swb_hit = pmm_q && swb_q && any_irq;
    end

    // Register update; switchback overrides a same-cycle write of the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q   <= '0;
            pmm_q     <= 1'b0;
            swb_q     <= 1'b0;
            wake_rc_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                ratio_q   <= cfg_ratio;
                swb_q     <= cfg_swb;
                wake_rc_q <= cfg_wake_rc;
                pmm_q     <= cfg_pmm;
            end
            if (swb_hit) begin
                pmm_q <= 1'b0;
            end
        end
    end

    // R5
    swb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pmm_q && swb_q && (|(irq_req & irq_en))) |=> !pmm_q);
endmodule

// File: rtl/clkpm_divider.sv
// Power-of-two divider on source ticks. The division exponent is loaded only
// at the terminal tick (or on restart), so a period in progress is never cut
// short by a register write. Assumes tick is a one-cycle pulse.
module clkpm_divider #(
    parameter int CNT_W = 8,
    parameter int LOG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             restart,
    input  logic [LOG_W-1:0] req_log2,
    input  logic [LOG_W-1:0] fast_log2,
    output logic             clk_en
);
    logic [CNT_W-1:0] cnt;
    logic [LOG_W-1:0] act_log2;
    logic [CNT_W-1:0] term_val;
    logic             at_term;

    // Terminal count for the active exponent (wraps to all ones at CNT_W).
    always_comb begin
        term_val = (CNT_W'(1) << act_log2) - CNT_W'(1);
        at_term  = (cnt == term_val);
    end

    // Count ticks, reload the exponent at terminal count, emit the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            act_log2 <= '0;
            clk_en   <= 1'b0;
        end else if (restart) begin
            cnt      <= '0;
            act_log2 <= fast_log2;
            clk_en   <= 1'b0;
        end else if (tick) begin
            clk_en <= at_term;
            if (at_term) begin
                cnt      <= '0;
                act_log2 <= req_log2;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end else begin
            clk_en <= 1'b0;
        end
    end

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= term_val);
    // R3
    act_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_log2 != $past(act_log2)) |-> ($past(tick && at_term) || $past(restart)));
endmodule

// File: rtl/clkpm_osc_fsm.sv
// Oscillator state machine: run from RC, run from crystal, stop, or wait for
// the crystal after a stop. Assumes rdy_s is already synchronized and that
// the crystal ready input falls while the crystal is halted.
module clkpm_osc_fsm #(
    parameter int               N_IRQ    = 4,
    parameter logic [N_IRQ-1:0] EXT_MASK = 4'b0011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rc_tick,
    input  logic             rdy_s,
    input  logic             stop_req,
    input  logic             wake_rc,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic [N_IRQ-1:0] irq_en,
    output logic             sel_rc,
    output logic             rc_run,
    output logic             xtal_run,
    output logic             counting,
    output logic             stopped
);
    import clkpm_pkg::*;

    osc_state_e st, st_nxt;
    logic       wake;

    // Next state from stop requests, wake events and crystal readiness.
    always_comb begin
        wake   = |(irq_req & irq_en & EXT_MASK);
        st_nxt = st;
        case (st)
            OSC_RC:   if (stop_req) st_nxt = OSC_STOP;
                      else if (rc_tick && rdy_s) st_nxt = OSC_XTAL;
            OSC_XTAL: if (stop_req) st_nxt = OSC_STOP;
            OSC_STOP: if (wake) st_nxt = wake_rc ? OSC_RC : OSC_WAIT;
            OSC_WAIT: if (stop_req) st_nxt = OSC_STOP;
                      else if (rdy_s) st_nxt = OSC_XTAL;
            default:  st_nxt = OSC_RC;
        endcase
    end

    // State register; reset starts on RC with the crystal warming.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= OSC_RC;
        else        st <= st_nxt;
    end

    // Decode run controls and source selection.
    always_comb begin
        sel_rc   = (st == OSC_RC);
        rc_run   = (st == OSC_RC);
        xtal_run = (st != OSC_STOP);
        counting = (st == OSC_RC) || (st == OSC_XTAL);
        stopped  = (st == OSC_STOP);
    end

    // R7
    leave_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != OSC_STOP) && ($past(st) == OSC_STOP)) |-> $past(wake));
    // R9
    sel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sel_rc) |-> ($past(rc_tick && rdy_s) || (st == OSC_STOP)));
endmodule

// File: rtl/clkpm_ctrl.sv
// Top of the clock divider and low-power mode controller. Selects the tick
// source, gates it by power state, and derives the division exponent from
// the mode register. Assumes ticks are one-cycle pulses in the clk domain.
module clkpm_ctrl #(
    parameter int               RATIO_W     = 2,
    parameter int               PMM_LOG2    = 8,
    parameter int               N_IRQ       = 4,
    parameter logic [N_IRQ-1:0] EXT_MASK    = 4'b0011,
    parameter int               SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xtal_tick,
    input  logic               rc_tick,
    input  logic               xtal_rdy_raw,
    input  logic               cfg_we,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic               cfg_pmm,
    input  logic               cfg_swb,
    input  logic               cfg_wake_rc,
    input  logic               cfg_stop,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic [N_IRQ-1:0]   irq_en,
    output logic               clk_en,
    output logic               xtal_run,
    output logic               rc_run,
    output logic               sel_rc,
    output logic               stop_q,
    output logic               pmm_q,
    output logic [RATIO_W-1:0] ratio_q
);
    localparam int CNT_W = PMM_LOG2;
    localparam int LOG_W = $clog2(PMM_LOG2 + 1);

    logic             rdy_s;
    logic             wake_rc_q;
    logic             swb_hit;
    logic             counting;
    logic             tick_g;
    logic [LOG_W-1:0] req_log2;
    logic [LOG_W-1:0] fast_log2;

    clkpm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(xtal_rdy_raw), .q_sync(rdy_s)
    );

    clkpm_modereg #(.RATIO_W(RATIO_W), .N_IRQ(N_IRQ)) u_mode (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ratio(cfg_ratio),
        .cfg_pmm(cfg_pmm), .cfg_swb(cfg_swb), .cfg_wake_rc(cfg_wake_rc),
        .irq_req(irq_req), .irq_en(irq_en), .ratio_q(ratio_q),
        .pmm_q(pmm_q), .wake_rc_q(wake_rc_q), .swb_hit(swb_hit)
    );

    clkpm_osc_fsm #(.N_IRQ(N_IRQ), .EXT_MASK(EXT_MASK)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rc_tick(rc_tick), .rdy_s(rdy_s),
        .stop_req(cfg_we && cfg_stop), .wake_rc(wake_rc_q),
        .irq_req(irq_req), .irq_en(irq_en), .sel_rc(sel_rc),
        .rc_run(rc_run), .xtal_run(xtal_run), .counting(counting),
        .stopped(stop_q)
    );

    // Pick the active source tick and the exponent the divider should load.
    always_comb begin
        tick_g    = counting && (sel_rc ? rc_tick : xtal_tick);
        fast_log2 = LOG_W'(ratio_q);
        req_log2  = pmm_q ? LOG_W'(PMM_LOG2) : fast_log2;
    end

    clkpm_divider #(.CNT_W(CNT_W), .LOG_W(LOG_W)) u_div (
        .clk(clk), .rst_n(rst_n), .tick(tick_g), .restart(swb_hit),
        .req_log2(req_log2), .fast_log2(fast_log2), .clk_en(clk_en)
    );

    // R6
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && $past(stop_q)) |-> (!clk_en && !xtal_run && !rc_run));
endmodule

// File: tb/clkpm_ctrl_tb.sv
// Scoreboard bench: tick drivers queue the expected strobe level, a monitor
// compares it at the falling edge of the cycle it is due.
module clkpm_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xtal_tick = 1'b0, rc_tick = 1'b0, xtal_rdy_raw = 1'b0;
    logic       cfg_we = 1'b0, cfg_pmm = 1'b0, cfg_swb = 1'b0;
    logic       cfg_wake_rc = 1'b0, cfg_stop = 1'b0;
    logic [1:0] cfg_ratio = 2'd0;
    logic [3:0] irq_req = 4'd0, irq_en = 4'd0;
    logic       clk_en, xtal_run, rc_run, sel_rc, stop_q, pmm_q;
    logic [1:0] ratio_q;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 1'b0;
    bit    exp_q[$];
    int    due_q[$];
    string tag_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    clkpm_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .rc_tick(rc_tick),
        .xtal_rdy_raw(xtal_rdy_raw), .cfg_we(cfg_we), .cfg_ratio(cfg_ratio),
        .cfg_pmm(cfg_pmm), .cfg_swb(cfg_swb), .cfg_wake_rc(cfg_wake_rc),
        .cfg_stop(cfg_stop), .irq_req(irq_req), .irq_en(irq_en),
        .clk_en(clk_en), .xtal_run(xtal_run), .rc_run(rc_run),
        .sel_rc(sel_rc), .stop_q(stop_q), .pmm_q(pmm_q), .ratio_q(ratio_q)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pop every expectation due in this cycle.
    always @(negedge clk) begin
        while (due_q.size() > 0 && due_q[0] == cyc) begin
            chk(tag_q[0], int'(clk_en), int'(exp_q[0]));
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    // Driver: one tick of one source, strobe expectation queued.
    task automatic tick(input bit use_rc, input bit exp, input string tag);
        if (use_rc) rc_tick = 1'b1; else xtal_tick = 1'b1;
        exp_q.push_back(exp);
        due_q.push_back(cyc + 1);
        tag_q.push_back(tag);
        @(negedge clk);
        rc_tick = 1'b0;
        xtal_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] r, input bit p, input bit s,
                      input bit w, input bit st);
        cfg_we = 1'b1; cfg_ratio = r; cfg_pmm = p; cfg_swb = s;
        cfg_wake_rc = w; cfg_stop = st;
        @(negedge clk);
        cfg_we = 1'b0; cfg_stop = 1'b0;
    endtask

    task automatic irq(input logic [3:0] v);
        irq_req = v;
        @(negedge clk);
        irq_req = 4'd0;
    endtask

    task automatic reset_checks(input string tag);
        chk(tag, sel_rc, 1); chk(tag, rc_run, 1); chk(tag, xtal_run, 1);
        chk(tag, stop_q, 0); chk(tag, pmm_q, 0); chk(tag, ratio_q, 0);
        chk(tag, clk_en, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        reset_checks("R1 reset state");
        // R1 / R2: divide by 1 after reset
        for (int i = 0; i < 3; i++) tick(1, 1, "R1 R2 div1");
        // R3: change from div1 takes effect after the next tick
        wr(2'd2, 0, 0, 0, 0);
        tick(1, 1, "R3 old div1 period");
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 3; i++) tick(1, 0, "R2 div4 idle");
            tick(1, 1, "R2 div4 pulse");
        end
        // R3: mid-period change keeps old length
        tick(1, 0, "R3 div4 first");
        wr(2'd1, 0, 0, 0, 0);
        tick(1, 0, "R3 old div4 2nd");
        tick(1, 0, "R3 old div4 3rd");
        tick(1, 1, "R3 old div4 end");
        for (int i = 0; i < 2; i++) begin
            tick(1, 0, "R2 div2 idle");
            tick(1, 1, "R2 div2 pulse");
        end
        // R2: div8
        wr(2'd3, 0, 0, 0, 0);
        tick(1, 0, "R3 div2 tail");
        tick(1, 1, "R3 div2 end");
        for (int i = 0; i < 7; i++) tick(1, 0, "R2 div8 idle");
        tick(1, 1, "R2 div8 pulse");
        // R4: divide by 256 overriding ratio 3
        wr(2'd3, 1, 0, 0, 0);
        chk("R4 pmm readback", pmm_q, 1);
        for (int i = 0; i < 7; i++) tick(1, 0, "R3 R4 old div8");
        tick(1, 1, "R3 R4 load 256");
        for (int i = 0; i < 255; i++) tick(1, 0, "R4 div256 idle");
        tick(1, 1, "R4 div256 pulse");
        // R5: no switchback when disabled
        irq_en = 4'b1111;
        wr(2'd1, 1, 0, 0, 0);
        irq(4'b0100);
        chk("R5 swb disabled keeps pmm", pmm_q, 1);
        irq_en = 4'b0000;
        wr(2'd1, 1, 1, 0, 0);
        irq(4'b0100);
        chk("R5 disabled irq keeps pmm", pmm_q, 1);
        for (int i = 0; i < 3; i++) tick(1, 0, "R4 div256 partial");
        irq_en = 4'b1111;
        irq(4'b0100);
        chk("R5 switchback clears pmm", pmm_q, 0);
        chk("R5 ratio kept", ratio_q, 1);
        for (int i = 0; i < 2; i++) begin
            tick(1, 0, "R5 restart div2 idle");
            tick(1, 1, "R5 restart div2 pulse");
        end
        // R9 / R10: RC to crystal after reset warm-up
        wr(2'd0, 0, 0, 0, 0);
        tick(1, 0, "R3 div2 tail");
        tick(1, 1, "R3 div2 end");
        xtal_rdy_raw = 1'b1;
        idle(3);
        tick(0, 0, "R9 xtal tick ignored on RC");
        chk("R9 still on RC", sel_rc, 1);
        tick(1, 1, "R9 switching RC tick counted");
        chk("R9 sel_rc after switch", sel_rc, 0);
        chk("R9 rc_run after switch", rc_run, 0);
        chk("R9 xtal_run after switch", xtal_run, 1);
        tick(0, 1, "R9 xtal counted");
        tick(1, 0, "R9 rc ignored on xtal");
        // R6 / R7 / R8: stop and wait-for-crystal wake
        wr(2'd0, 0, 0, 0, 1);
        chk("R6 stop_q", stop_q, 1);
        chk("R6 xtal_run", xtal_run, 0);
        chk("R6 rc_run", rc_run, 0);
        xtal_rdy_raw = 1'b0;
        tick(0, 0, "R6 xtal in stop");
        tick(1, 0, "R6 rc in stop");
        irq_en = 4'b1111;
        irq(4'b0100);
        chk("R7 internal irq no wake", stop_q, 1);
        irq_en = 4'b0000;
        irq(4'b0001);
        chk("R7 disabled ext irq no wake", stop_q, 1);
        irq_en = 4'b0001;
        irq(4'b0001);
        chk("R7 ext irq wakes", stop_q, 0);
        chk("R8 xtal_run", xtal_run, 1);
        chk("R8 rc_run", rc_run, 0);
        chk("R8 sel_rc", sel_rc, 0);
        tick(0, 0, "R8 held until ready");
        xtal_rdy_raw = 1'b1;
        idle(1);
        tick(0, 0, "R10 sync stage 2");
        tick(0, 0, "R10 sync stage 3");
        tick(0, 1, "R10 counted after sync");
        // R9: wake on RC
        wr(2'd0, 0, 0, 1, 1);
        xtal_rdy_raw = 1'b0;
        idle(3);
        irq_en = 4'b0010;
        irq(4'b0010);
        chk("R9 wake stop_q", stop_q, 0);
        chk("R9 wake sel_rc", sel_rc, 1);
        chk("R9 wake rc_run", rc_run, 1);
        chk("R9 wake xtal_run", xtal_run, 1);
        tick(1, 1, "R9 rc counted at once");
        tick(0, 0, "R9 xtal ignored while warming");
        xtal_rdy_raw = 1'b1;
        idle(3);
        tick(1, 1, "R9 switch tick");
        chk("R9 moved to xtal", sel_rc, 0);
        // R7 / R1: reset leaves stop and clears the mode register
        wr(2'd2, 1, 0, 0, 1);
        chk("R7 in stop before reset", stop_q, 1);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        reset_checks("R7 R1 reset exits stop");
        idle(2);
        chk("scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule